// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs clause-22 style management transactions towards one or more targets sharing an MDC clock and a single bidirectional MDIO line. The line is presented as three separate signals: a driven value, an output enable and the sensed value, so that the pad or a board-level pull-up sits outside the block. A host starts a frame with a one-cycle command that carries a read/write flag, a 5-bit target address, a 5-bit register address and, for a write, a 16-bit data word.

Each frame begins with a long all-ones preamble, then the start pattern, the opcode and the two addresses, then a turnaround and sixteen data bits. On a read the block releases the line after the register address and checks that the target pulls the second turnaround bit low. If nothing does, the block treats the target as missing: it keeps clocking idle cycles, raises a no-responder flag and hands back all-ones. The MDC half-period is a parameter counted in system clocks, and the whole frame has a fixed length in clocks for each of the three outcomes.

Top module: `mdio_master`

## Requirements
- R1: Every frame opens with 32 MDC periods in which `mdio_oe` is 1 and `mdio_o` is 1.
- R2: After the preamble the block drives the start pattern 0 then 1, then the opcode 1,0 for a read (`cmd_read`=1) or 0,1 for a write.
- R3: The opcode is followed by the 5-bit target address and then the 5-bit register address, both most significant bit first.
- R4: On a write the block drives the turnaround as 1 then 0, then the 16 data bits MSB first, then holds `mdio_oe` at 0 for one further MDC period; a write frame lasts 65 MDC periods.
- R5: On a read `mdio_oe` is 0 from the first turnaround period on; each of the 16 data bits is taken from `mdio_i` at the end of the high half of its MDC period, MSB first, and one idle period follows; the frame lasts 65 MDC periods and `rd_data` then holds the word read.
- R6: If `mdio_i` is not 0 at the end of the second turnaround period of a read, the block clocks 32 further MDC periods (80 in all), then sets `no_resp` to 1 and `rd_data` to 16'hFFFF.
- R7: MDC idles at 0, each MDC half-period lasts `MDC_HALF_CYCLES` system clocks, each frame starts with a low half, and `mdio_o`/`mdio_oe` only change on the clock where MDC falls or where a frame starts or ends.
- R8: A command presented while `busy` is 1 is ignored: it does not alter the running frame and starts no frame afterwards.
- R9: `busy` rises on the clock after the command is accepted; `done` is a one-clock pulse on the clock `busy` falls, exactly 2·`MDC_HALF_CYCLES`·(frame periods) clocks after acceptance.
- R10: After reset `mdc`, `mdio_oe`, `busy`, `done` and `no_resp` are 0.
- R11: `no_resp` and `rd_data` change only together with `done`; a successful read or a write leaves `no_resp` at 0, and a write leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe, honoured only while idle |
| cmd_read | input | 1 | 1 = read frame, 0 = write frame |
| cmd_phy | input | 5 | Target address |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-clock end-of-frame pulse |
| rd_data | output | 16 | Data of the last read (all-ones if no target answered) |
| no_resp | output | 1 | Last read found no target |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven on MDIO |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | Sensed MDIO level |

## Verification
A behavioural target in the bench decodes every frame from MDC edges, stores writes and answers reads, and it can be switched off or addressed at a different target address so that the line stays pulled high. The bench tracks the exact clock of every MDC edge and of `done`; a divider off by one, a frame one period short or long, or an absent-target branch that skips its 32 idle periods shows up as a mismatch on the first wrong clock. Read-back of alternating and edge-bit patterns catches a data shift in the wrong direction or sampled on the wrong half period, and a command injected mid-frame catches a design that restarts or corrupts a running frame.

// File: rtl/mdio_master_pkg.sv
// Package: protocol constants, command record and frame builder shared by
// the MDIO master. Slot numbers count MDC periods from the start of a frame.
package mdio_master_pkg;

    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 5;
    localparam int SLOT_W   = 7;
    localparam int FRAME_W  = 64;

    // Slot landmarks (slot = one MDC period, low half then high half)
    localparam logic [SLOT_W-1:0] SLOT_RD_RELEASE  = 7'd46; // first read turnaround
    localparam logic [SLOT_W-1:0] SLOT_TA2         = 7'd47; // turnaround bit checked
    localparam logic [SLOT_W-1:0] SLOT_DATA_FIRST  = 7'd48;
    localparam logic [SLOT_W-1:0] SLOT_DATA_LAST   = 7'd63;
    localparam logic [SLOT_W-1:0] SLOT_WR_RELEASE  = 7'd64; // write release period
    localparam logic [SLOT_W-1:0] SLOT_FRAME_LAST  = 7'd64; // last slot, normal frames
    localparam logic [SLOT_W-1:0] SLOT_ABSENT_LAST = 7'd79; // last slot, no target

    typedef enum logic [1:0] {
        OPC_WRITE = 2'b01,
        OPC_READ  = 2'b10
    } mdio_opc_e;

    typedef struct packed {
        logic              rd;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } mdio_cmd_t;

    // Serial image of a frame, bit 63 leaves first.
    function automatic logic [FRAME_W-1:0] build_frame(input mdio_cmd_t c);
        mdio_opc_e opc;
        logic [1:0] ta;
        logic [DATA_W-1:0] dat;
        opc = c.rd ? OPC_READ : OPC_WRITE;
        ta  = c.rd ? 2'b00 : 2'b10;
        dat = c.rd ? '0 : c.wdata;
        return {32'hFFFF_FFFF, 2'b01, opc, c.phy, c.regad, ta, dat};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
// MDC generator. Runs only while 'run' is high; starts every frame with a
// full low half so that the first bit is stable before the first rising
// edge. 'slot_end' marks the clock on which MDC falls, ending one period.
// Assumes HALF >= 1.
module mdio_mdc_gen #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic slot_end
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] CNT_TOP = CW'(HALF - 1);

    logic [CW-1:0] cnt;
    logic          at_top;

    assign at_top   = (cnt == CNT_TOP);
    assign slot_end = run && mdc && at_top;

    // Count system clocks per half period and toggle MDC at the top.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (at_top) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_rx_shift.sv
// Receive shifter: collects read data MSB first, one bit per enable.
module mdio_rx_shift #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             din,
    output logic [WIDTH-1:0] word
);
    // Clear on a new command, otherwise shift in on each sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            word <= '0;
        end else if (shift_en) begin
            word <= {word[WIDTH-2:0], din};
        end
    end
endmodule

// File: rtl/mdio_frame_ctrl.sv
// Frame sequencer. Accepts a command while idle, shifts the preloaded frame
// image out one bit per MDC period, releases the line at the protocol
// landmarks, checks the turnaround on reads and extends the frame when no
// target answers. Outputs launch on the MDC falling clock; input is taken
// on that same clock, i.e. at the end of the high half.
module mdio_frame_ctrl
    import mdio_master_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  mdio_cmd_t         cmd,
    input  logic              slot_end,
    input  logic              mdio_i,
    input  logic [DATA_W-1:0] rx_word,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              no_resp,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              rx_clear,
    output logic              rx_sample
);
    typedef enum logic {ST_IDLE, ST_RUN} st_e;

    st_e                state;
    logic [SLOT_W-1:0]  slot;
    logic [SLOT_W-1:0]  slot_nx;
    logic [SLOT_W-1:0]  last_slot;
    logic [FRAME_W-1:0] tx_sh;
    logic               rd_q;
    logic               absent_q;
    logic               oe_q;
    logic               oe_nx;
    logic               accept;

    assign accept   = (state == ST_IDLE) && cmd_valid;
    assign busy     = (state == ST_RUN);
    assign mdio_oe  = oe_q;
    assign mdio_o   = tx_sh[FRAME_W-1] & oe_q;
    assign rx_clear = accept;
    assign slot_nx  = slot + 1'b1;

    // Pick where the frame ends: normal length, or extended for no target.
    always_comb begin
        last_slot = (rd_q && absent_q) ? SLOT_ABSENT_LAST : SLOT_FRAME_LAST;
    end

    // Drive enable for the next period depends on frame direction.
    always_comb begin
        oe_nx = rd_q ? (slot_nx < SLOT_RD_RELEASE) : (slot_nx < SLOT_WR_RELEASE);
    end

    // Sample read data only inside the data window of an answered read.
    always_comb begin
        rx_sample = busy && slot_end && rd_q && !absent_q &&
                    (slot >= SLOT_DATA_FIRST) && (slot <= SLOT_DATA_LAST);
    end

    // Main sequencer: accept, advance per MDC period, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            slot     <= '0;
            tx_sh    <= '0;
            rd_q     <= 1'b0;
            absent_q <= 1'b0;
            oe_q     <= 1'b0;
            done     <= 1'b0;
            rd_data  <= '0;
            no_resp  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        state    <= ST_RUN;
                        slot     <= '0;
                        tx_sh    <= build_frame(cmd);
                        rd_q     <= cmd.rd;
                        absent_q <= 1'b0;
                        oe_q     <= 1'b1;
                    end
                end
                ST_RUN: begin
                    if (slot_end) begin
                        if (slot == last_slot) begin
                            state   <= ST_IDLE;
                            oe_q    <= 1'b0;
                            done    <= 1'b1;
                            no_resp <= rd_q && absent_q;
                            if (rd_q) begin
                                rd_data <= absent_q ? '1 : rx_word;
                            end
                        end else begin
                            slot  <= slot_nx;
                            tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
                            oe_q  <= oe_nx;
                            if (rd_q && (slot == SLOT_TA2) && mdio_i) begin
                                absent_q <= 1'b1;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mdio_master.sv
// MDIO management frame master (top). Joins the MDC generator, the frame
// sequencer and the receive shifter. MDIO is split into drive value, drive
// enable and sensed level; an external pull-up is assumed on the line.
module mdio_master
    import mdio_master_pkg::*;
#(
    parameter int MDC_HALF_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_read,
    input  logic [ADDR_W-1:0] cmd_phy,
    input  logic [ADDR_W-1:0] cmd_reg,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              no_resp,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    mdio_cmd_t         cmd;
    logic              slot_end;
    logic              rx_clear;
    logic              rx_sample;
    logic [DATA_W-1:0] rx_word;

    assign cmd = '{rd: cmd_read, phy: cmd_phy, regad: cmd_reg, wdata: cmd_wdata};

    mdio_mdc_gen #(
        .HALF(MDC_HALF_CYCLES)
    ) u_mdc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .mdc      (mdc),
        .slot_end (slot_end)
    );

    mdio_frame_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd       (cmd),
        .slot_end  (slot_end),
        .mdio_i    (mdio_i),
        .rx_word   (rx_word),
        .busy      (busy),
        .done      (done),
        .rd_data   (rd_data),
        .no_resp   (no_resp),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rx_clear  (rx_clear),
        .rx_sample (rx_sample)
    );

    mdio_rx_shift #(
        .WIDTH(DATA_W)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (rx_clear),
        .shift_en (rx_sample),
        .din      (mdio_i),
        .word     (rx_word)
    );
endmodule

// File: rtl/mdio_master_chk.sv
// Checker for the MDIO master: port-level protocol properties, bound below.
module mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        busy,
    input logic        done,
    input logic [15:0] rd_data,
    input logic        no_resp,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    // R7
    launch_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(mdio_oe) || !$stable(mdio_o)) |-> ($fell(mdc) || $rose(busy) || $fell(busy)));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R9
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $fell(busy)));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    start_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));

    // R11
    resp_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(no_resp) |-> done);

    // R11
    rdata_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rd_data) |-> done);
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .done      (done),
    .rd_data   (rd_data),
    .no_resp   (no_resp),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/mdio_master_tb.sv
// Bench: behavioural MDIO target plus per-clock timing model of the master.
module mdio_master_tb;
    localparam int HALF    = 3;
    localparam int RSP_PHY = 5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic        cmd_read;
    logic [4:0]  cmd_phy;
    logic [4:0]  cmd_reg;
    logic [15:0] cmd_wdata;
    logic        busy, done, no_resp, mdc, mdio_o, mdio_oe;
    logic [15:0] rd_data;
    logic        mdio_i;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2 clk = ~clk; // 250 MHz

    mdio_master #(.MDC_HALF_CYCLES(HALF)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
        .cmd_phy(cmd_phy), .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .no_resp(no_resp),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    function automatic logic [15:0] init_val(input int i);
        return 16'h3C00 ^ (16'(i) * 16'h0111);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural target ----------------
    logic [15:0] mem [32];
    logic        rsp_on = 1'b1;
    logic        seen_bit [80];
    logic        seen_oe  [80];
    int          r_idx = 0;

    initial begin
        logic mdc_q, busy_q, hit;
        logic [1:0] op;
        logic [4:0] pa, ra;
        logic [15:0] w;
        for (int i = 0; i < 32; i++) mem[i] = init_val(i);
        mdio_i = 1'b1;
        mdc_q = 1'b0; busy_q = 1'b0; hit = 1'b0; op = '0; pa = '0; ra = '0;
        forever begin
            @(negedge clk);
            if (busy && !busy_q) begin
                r_idx = 0;
                hit = 1'b0;
                for (int i = 0; i < 80; i++) begin seen_bit[i] = 1'bx; seen_oe[i] = 1'bx; end
            end
            if (mdc && !mdc_q && r_idx < 80) begin
                seen_bit[r_idx] = mdio_o;
                seen_oe[r_idx]  = mdio_oe;
            end
            if (!mdc && mdc_q) begin
                r_idx++;
                if (r_idx == 46) begin
                    op = {seen_bit[34], seen_bit[35]};
                    for (int i = 0; i < 5; i++) begin
                        pa[4-i] = seen_bit[36+i];
                        ra[4-i] = seen_bit[41+i];
                    end
                    hit = rsp_on && (pa == 5'(RSP_PHY)) && !seen_bit[32] && seen_bit[33];
                end
                mdio_i = 1'b1;
                if (hit && op == 2'b10) begin
                    if (r_idx == 47) mdio_i = 1'b0;
                    else if (r_idx >= 48 && r_idx <= 63) mdio_i = mem[ra][63-r_idx];
                end
                if (hit && op == 2'b01 && r_idx == 64) begin
                    for (int i = 0; i < 16; i++) w[15-i] = seen_bit[48+i];
                    mem[ra] = w;
                end
            end
            mdc_q = mdc;
            busy_q = busy;
        end
    end

    // ---------------- transaction with per-clock model ----------------
    task automatic run_txn(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd, input bit exp_absent,
                           input logic [15:0] exp_rd, input int inj);
        int len, tend;
        bit ok;
        logic [15:0] prev_rd;
        len  = (rd && exp_absent) ? 80 : 65;
        tend = 2 * HALF * len;
        prev_rd = rd_data;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_read = rd; cmd_phy = pa; cmd_reg = ra; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int c = 0; c <= tend; c++) begin
            // R7 MDC waveform and R9 busy/done timing, every clock
            chk((mdc == (((c / HALF) % 2) == 1)) && (busy == (c < tend)), "R7",
                {busy, mdc}, {(c < tend), (((c / HALF) % 2) == 1)});
            chk(done == (c == tend), "R9", done, (c == tend));
            if (c < tend) begin
                if (c == inj) begin // R8 command while busy
                    cmd_valid = 1'b1; cmd_read = 1'b0; cmd_phy = 5'(RSP_PHY);
                    cmd_reg = 5'd2; cmd_wdata = 16'hDEAD;
                end else begin
                    cmd_valid = 1'b0;
                end
                @(negedge clk);
            end
        end
        cmd_valid = 1'b0;
        // R1 preamble
        ok = 1;
        for (int i = 0; i < 32; i++) ok &= (seen_bit[i] === 1'b1) && (seen_oe[i] === 1'b1);
        chk(ok, "R1", ok, 1);
        // R2 start and opcode
        chk({seen_bit[32], seen_bit[33], seen_bit[34], seen_bit[35]} === (rd ? 4'b0110 : 4'b0101),
            "R2", {seen_bit[32], seen_bit[33], seen_bit[34], seen_bit[35]}, rd ? 4'b0110 : 4'b0101);
        // R3 addresses
        ok = 1;
        for (int i = 0; i < 5; i++) ok &= (seen_bit[36+i] === pa[4-i]) && (seen_bit[41+i] === ra[4-i]);
        chk(ok, "R3", ok, 1);
        if (!rd) begin
            // R4 turnaround, data, release
            ok = (seen_bit[46] === 1'b1) && (seen_bit[47] === 1'b0) && (seen_oe[64] === 1'b0);
            for (int i = 0; i < 64; i++) ok &= (seen_oe[i] === 1'b1);
            for (int i = 0; i < 16; i++) ok &= (seen_bit[48+i] === wd[15-i]);
            chk(ok, "R4", ok, 1);
            chk(no_resp == 1'b0 && rd_data == prev_rd, "R11", {no_resp, rd_data}, {1'b0, prev_rd});
        end else begin
            ok = 1;
            for (int i = 0; i < 46; i++) ok &= (seen_oe[i] === 1'b1);
            for (int i = 46; i < len; i++) ok &= (seen_oe[i] === 1'b0);
            chk(ok, "R5", ok, 1);
            if (exp_absent) begin
                chk(no_resp == 1'b1 && rd_data == 16'hFFFF, "R6", {no_resp, rd_data}, {1'b1, 16'hFFFF});
            end else begin
                chk(rd_data == exp_rd, "R5", rd_data, exp_rd);
                chk(no_resp == 1'b0, "R11", no_resp, 0);
            end
        end
    endtask

    initial begin
        rst_n = 1'b0; cmd_valid = 1'b0; cmd_read = 1'b0;
        cmd_phy = '0; cmd_reg = '0; cmd_wdata = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk({mdc, mdio_oe, busy, done, no_resp} == 5'b0, "R10", {mdc, mdio_oe, busy, done, no_resp}, 0);

        run_txn(1'b0, 5'(RSP_PHY), 5'd3, 16'hA5C3, 1'b0, 16'h0, -1);
        run_txn(1'b1, 5'(RSP_PHY), 5'd3, 16'h0, 1'b0, 16'hA5C3, -1);
        run_txn(1'b0, 5'(RSP_PHY), 5'd31, 16'h8001, 1'b0, 16'h0, 100);
        // R8: injected command must not have started another frame
        repeat (3) begin
            @(negedge clk);
            chk(busy == 1'b0, "R8", busy, 0);
        end
        run_txn(1'b1, 5'(RSP_PHY), 5'd31, 16'h0, 1'b0, 16'h8001, -1);
        run_txn(1'b1, 5'(RSP_PHY), 5'd2, 16'h0, 1'b0, init_val(2), 200); // R8 data untouched
        run_txn(1'b1, 5'd9, 5'd3, 16'h0, 1'b1, 16'h0, -1);               // R6 wrong target
        run_txn(1'b1, 5'(RSP_PHY), 5'd0, 16'h0, 1'b0, init_val(0), -1);  // R11 flag clears
        rsp_on = 1'b0;
        run_txn(1'b1, 5'(RSP_PHY), 5'd3, 16'h0, 1'b1, 16'h0, -1);        // R6 line pulled up
        rsp_on = 1'b1;
        run_txn(1'b0, 5'(RSP_PHY), 5'd7, 16'h5A3C, 1'b0, 16'h0, -1);
        chk(no_resp == 1'b0 && rd_data == 16'hFFFF, "R11", {no_resp, rd_data}, {1'b0, 16'hFFFF});
        run_txn(1'b1, 5'(RSP_PHY), 5'd7, 16'h0, 1'b0, 16'h5A3C, -1);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R9 watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule